// File: doc/BRIEF.md
# Load/Store Byte-Lane Unit

This unit sits between a core's execute stage and a 32-bit data memory that is addressed by word. For each access it works out the effective byte address as a base register plus a sign-extended 12-bit offset. It then issues the word address, a 4-bit lane enable and, for stores, a write word in which the stored byte or halfword is copied into every lane. When the memory returns a word for a load, the unit moves the addressed byte or halfword down to bit 0. It then widens that value to 32 bits with sign or zero fill.

The unit does not split unaligned accesses. A halfword on an odd address, or a word whose address is not a multiple of four, raises a one-cycle misalignment flag and no memory access is issued. A size code that is not defined for the access type raises an illegal flag in the same way. Instructions with other opcodes pass through without any effect.

The request path is registered: outputs appear one clock after the request. The load result appears one clock after the memory reports its data valid. It uses the lane offset and size of the most recent load that was issued.

Top module: `lsu_lane_unit`

## Requirements
- R1: After synchronous active-low reset, mem_valid_o, mem_write_o, mem_addr_o, mem_be_o, mem_wdata_o, misaligned_o, illegal_o, load_valid_o and load_data_o are all zero.
- R2: One clock after an accepted request, mem_addr_o equals bits [31:2] of base_i plus offset_i sign-extended from bit 11. mem_valid_o is 1, and mem_write_o is 1 for a store (opcode 0x23) and 0 for a load (opcode 0x03).
- R3: For a byte access (funct3 0x0 store, 0x0 or 0x4 load), mem_be_o has only bit A set, where A is effective address bits [1:0]. For a store, mem_wdata_o holds store_data_i[7:0] in all four byte lanes.
- R4: For a halfword access (funct3 0x1 store, 0x1 or 0x5 load) with even address, mem_be_o is 4'b0011 when address bit 1 is 0 and 4'b1100 when it is 1. For a store, mem_wdata_o holds store_data_i[15:0] in both halves.
- R5: For a word access (funct3 0x2) with address bits [1:0] zero, mem_be_o is 4'b1111. For a store, mem_wdata_o equals store_data_i.
- R6: A halfword access with address bit 0 set, or a word access with address bits [1:0] nonzero, gives misaligned_o = 1 for one cycle, with mem_valid_o = 0 and mem_be_o = 0.
- R7: A load with funct3 0x3, 0x6 or 0x7, or a store with funct3 0x3 to 0x7, gives illegal_o = 1 for one cycle, with misaligned_o = 0, mem_valid_o = 0 and mem_be_o = 0.
- R8: A request whose opcode is neither 0x03 nor 0x23 is ignored. The next cycle shows every request output at zero.
- R9: A signed load (funct3 0x0 byte, 0x1 halfword) shifts the returned word right by 8 times address bits [1:0]. It then sign-extends from bit 7 or bit 15.
- R10: An unsigned load (funct3 0x4 byte, 0x5 halfword) uses the same shift and fills the upper bits with zeros.
- R11: A word load (funct3 0x2) returns mem_rdata_i unchanged.
- R12: load_valid_o is 1 exactly one clock after mem_rvalid_i is 1. load_data_o is formed using the size and lane of the most recently issued load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | Request present this cycle |
| opcode_i | input | 7 | Instruction major opcode |
| funct3_i | input | 3 | Size and sign code |
| base_i | input | 32 | Base register value |
| offset_i | input | 12 | Signed address offset |
| store_data_i | input | 32 | Data register value for stores |
| mem_valid_o | output | 1 | Memory access issued |
| mem_write_o | output | 1 | Access is a write |
| mem_addr_o | output | 30 | Word address |
| mem_be_o | output | 4 | Byte lane enables |
| mem_wdata_o | output | 32 | Lane-replicated write data |
| misaligned_o | output | 1 | Unaligned access rejected |
| illegal_o | output | 1 | Undefined size code rejected |
| mem_rdata_i | input | 32 | Word returned by memory |
| mem_rvalid_i | input | 1 | Returned word is valid |
| load_valid_o | output | 1 | Load result valid |
| load_data_o | output | 32 | Extended load result |

## Verification
On every cycle, the assertions check these points: a rejected access never issues a memory cycle or enables a lane, and an issued access enables one, two or four lanes. A single-lane store carries four identical bytes, a write is always an issued access, and each returned word yields a result one cycle later. Only the directed scenarios can show that values are correct: the effective-address sum with negative offsets, which lane each address selects, and sign versus zero fill. They also show that the load result follows the lane recorded at issue and that foreign opcodes are ignored.

// File: rtl/lsu_pkg.sv
// Shared constants and types for the load/store byte-lane unit.
// Assumes a 32-bit data word split into four byte lanes.
package lsu_pkg;
    localparam logic [6:0] OPC_LOAD  = 7'h03;
    localparam logic [6:0] OPC_STORE = 7'h23;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_NONE = 2'b11
    } size_e;
endpackage

// File: rtl/lsu_ea_calc.sv
// Effective address adder: base plus sign-extended offset.
// Assumes OFF_W <= ADDR_W; wraps modulo 2**ADDR_W.
module lsu_ea_calc #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [OFF_W-1:0]  offset_i,
    output logic [ADDR_W-1:0] ea_o
);
    localparam int EXT_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] off_ext;

    // Widen the offset by copying its top bit, then add.
    always_comb begin
        off_ext = {{EXT_W{offset_i[OFF_W-1]}}, offset_i};
        ea_o    = base_i + off_ext;
    end
endmodule

// File: rtl/lsu_lane_decode.sv
// Turns access kind, size code and low address bits into lane enables,
// replicated write data and fault flags. Purely combinational.
// Assumes DATA_W = 32 (four lanes); only one of is_load/is_store is set.
module lsu_lane_decode
    import lsu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / 8,
    parameter int LIDX_W = $clog2(LANES)
) (
    input  logic              is_load_i,
    input  logic              is_store_i,
    input  logic [2:0]        funct3_i,
    input  logic [LIDX_W-1:0] lane_i,
    input  logic [DATA_W-1:0] st_data_i,
    output logic [LANES-1:0]  be_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              misaligned_o,
    output logic              illegal_o
);
    size_e            size;
    logic             fault;
    logic [LANES-1:0] be_raw;

    // Classify the size code and check that it is defined for this access.
    always_comb begin
        size      = size_e'(funct3_i[1:0]);
        illegal_o = 1'b0;
        if (is_load_i)
            illegal_o = (size == SZ_NONE) || (funct3_i[2] && size == SZ_WORD);
        else if (is_store_i)
            illegal_o = funct3_i[2] || (size == SZ_NONE);
    end

    // Flag addresses that the size does not allow; illegal codes win.
    always_comb begin
        misaligned_o = 1'b0;
        if ((is_load_i || is_store_i) && !illegal_o) begin
            if (size == SZ_HALF) misaligned_o = lane_i[0];
            if (size == SZ_WORD) misaligned_o = (lane_i != '0);
        end
        fault = illegal_o || misaligned_o;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam logic [LIDX_W-1:0] LANE_ID = LIDX_W'(g);

        // Per-lane enable and per-lane source byte for the chosen size.
        always_comb begin
            case (size)
                SZ_BYTE: begin
                    be_raw[g]          = (lane_i == LANE_ID);
                    wdata_o[g*8 +: 8]  = st_data_i[7:0];
                end
                SZ_HALF: begin
                    be_raw[g]          = (lane_i[LIDX_W-1] == LANE_ID[LIDX_W-1]);
                    wdata_o[g*8 +: 8]  = st_data_i[(g % 2)*8 +: 8];
                end
                default: begin
                    be_raw[g]          = 1'b1;
                    wdata_o[g*8 +: 8]  = st_data_i[g*8 +: 8];
                end
            endcase
        end
    end

    // Suppress every lane when the access is rejected.
    always_comb be_o = fault ? '0 : be_raw;
endmodule

// File: rtl/lsu_load_extract.sv
// Aligns a returned word to the addressed lane and extends it to full width.
// Assumes DATA_W = 32 and a size code that was accepted at issue.
module lsu_load_extract
    import lsu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / 8,
    parameter int LIDX_W = $clog2(LANES)
) (
    input  logic [2:0]        funct3_i,
    input  logic [LIDX_W-1:0] lane_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [DATA_W-1:0] result_o
);
    logic [DATA_W-1:0] shifted;
    logic              fill;
    size_e             size;

    // Move the addressed lane down to bit 0.
    always_comb shifted = rdata_i >> {lane_i, 3'b000};

    // Choose the fill bit and width from the size and sign code.
    always_comb begin
        size = size_e'(funct3_i[1:0]);
        case (size)
            SZ_BYTE: begin
                fill     = !funct3_i[2] && shifted[7];
                result_o = {{(DATA_W-8){fill}}, shifted[7:0]};
            end
            SZ_HALF: begin
                fill     = !funct3_i[2] && shifted[15];
                result_o = {{(DATA_W-16){fill}}, shifted[15:0]};
            end
            default: begin
                fill     = 1'b0;
                result_o = rdata_i;
            end
        endcase
    end
endmodule

// File: rtl/lsu_lane_unit.sv
// Top of the load/store byte-lane unit. Registers the memory request one
// clock after the core request. Records the lane and size of the last
// issued load, and registers the extended load result one clock after the
// memory returns data. Assumes at most one load is outstanding at a time.
module lsu_lane_unit
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12,
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / 8,
    parameter int LIDX_W = $clog2(LANES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid_i,
    input  logic [6:0]               opcode_i,
    input  logic [2:0]               funct3_i,
    input  logic [ADDR_W-1:0]        base_i,
    input  logic [OFF_W-1:0]         offset_i,
    input  logic [DATA_W-1:0]        store_data_i,
    output logic                     mem_valid_o,
    output logic                     mem_write_o,
    output logic [ADDR_W-LIDX_W-1:0] mem_addr_o,
    output logic [LANES-1:0]         mem_be_o,
    output logic [DATA_W-1:0]        mem_wdata_o,
    output logic                     misaligned_o,
    output logic                     illegal_o,
    input  logic [DATA_W-1:0]        mem_rdata_i,
    input  logic                     mem_rvalid_i,
    output logic                     load_valid_o,
    output logic [DATA_W-1:0]        load_data_o
);
    logic [ADDR_W-1:0] ea;
    logic              is_load, is_store, accept;
    logic [LANES-1:0]  be_c;
    logic [DATA_W-1:0] wdata_c, ext_c;
    logic              mis_c, ill_c;
    logic [2:0]        pend_f3;
    logic [LIDX_W-1:0] pend_lane;

    // Decode which kind of access, if any, is requested this cycle.
    always_comb begin
        is_load  = req_valid_i && (opcode_i == OPC_LOAD);
        is_store = req_valid_i && (opcode_i == OPC_STORE);
        accept   = (is_load || is_store) && !mis_c && !ill_c;
    end

    lsu_ea_calc #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) ea_i (
        .base_i   (base_i),
        .offset_i (offset_i),
        .ea_o     (ea)
    );

    lsu_lane_decode #(.DATA_W(DATA_W), .LANES(LANES), .LIDX_W(LIDX_W)) dec_i (
        .is_load_i    (is_load),
        .is_store_i   (is_store),
        .funct3_i     (funct3_i),
        .lane_i       (ea[LIDX_W-1:0]),
        .st_data_i    (store_data_i),
        .be_o         (be_c),
        .wdata_o      (wdata_c),
        .misaligned_o (mis_c),
        .illegal_o    (ill_c)
    );

    lsu_load_extract #(.DATA_W(DATA_W), .LANES(LANES), .LIDX_W(LIDX_W)) ext_i (
        .funct3_i (pend_f3),
        .lane_i   (pend_lane),
        .rdata_i  (mem_rdata_i),
        .result_o (ext_c)
    );

    // Register the memory request and the fault flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_valid_o  <= 1'b0;
            mem_write_o  <= 1'b0;
            mem_addr_o   <= '0;
            mem_be_o     <= '0;
            mem_wdata_o  <= '0;
            misaligned_o <= 1'b0;
            illegal_o    <= 1'b0;
        end else begin
            mem_valid_o  <= accept;
            mem_write_o  <= accept && is_store;
            mem_addr_o   <= accept ? ea[ADDR_W-1:LIDX_W] : '0;
            mem_be_o     <= accept ? be_c : '0;
            mem_wdata_o  <= (accept && is_store) ? wdata_c : '0;
            misaligned_o <= mis_c;
            illegal_o    <= ill_c;
        end
    end

    // Remember the size code and lane of the last issued load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_f3   <= 3'b010;
            pend_lane <= '0;
        end else if (accept && is_load) begin
            pend_f3   <= funct3_i;
            pend_lane <= ea[LIDX_W-1:0];
        end
    end

    // Register the extended load result when memory returns data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_valid_o <= 1'b0;
            load_data_o  <= '0;
        end else begin
            load_valid_o <= mem_rvalid_i;
            if (mem_rvalid_i) load_data_o <= ext_c;
        end
    end

    // A rejected access issues nothing and enables no lane.
    p_fault_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        misaligned_o |-> (!mem_valid_o && mem_be_o == '0));
    p_illegal_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!mem_valid_o && !misaligned_o && mem_be_o == '0));
    // An issued access enables one, two or all lanes.
    p_lane_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid_o |-> ($countones(mem_be_o) == 1 || $countones(mem_be_o) == 2
                         || mem_be_o == '1));
    // A single-lane store carries the same byte in every lane.
    p_byte_copies_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_write_o && $countones(mem_be_o) == 1) |->
        (mem_wdata_o == {LANES{mem_wdata_o[7:0]}}));
    // A write strobe is only seen on an issued access.
    p_write_issued_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_write_o |-> mem_valid_o);
    // Returned data yields a result exactly one clock later.
    p_result_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rvalid_i |=> load_valid_o);
    p_no_spurious_result_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rvalid_i |=> !load_valid_o);
endmodule

// File: tb/lsu_lane_unit_tb_top.sv
module lsu_lane_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid_i = 1'b0;
    logic [6:0]  opcode_i = '0;
    logic [2:0]  funct3_i = '0;
    logic [31:0] base_i = '0;
    logic [11:0] offset_i = '0;
    logic [31:0] store_data_i = '0;
    logic        mem_valid_o, mem_write_o, misaligned_o, illegal_o;
    logic [29:0] mem_addr_o;
    logic [3:0]  mem_be_o;
    logic [31:0] mem_wdata_o;
    logic [31:0] mem_rdata_i = '0;
    logic        mem_rvalid_i = 1'b0;
    logic        load_valid_o;
    logic [31:0] load_data_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    lsu_lane_unit dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i),
        .opcode_i(opcode_i), .funct3_i(funct3_i), .base_i(base_i),
        .offset_i(offset_i), .store_data_i(store_data_i),
        .mem_valid_o(mem_valid_o), .mem_write_o(mem_write_o),
        .mem_addr_o(mem_addr_o), .mem_be_o(mem_be_o),
        .mem_wdata_o(mem_wdata_o), .misaligned_o(misaligned_o),
        .illegal_o(illegal_o), .mem_rdata_i(mem_rdata_i),
        .mem_rvalid_i(mem_rvalid_i), .load_valid_o(load_valid_o),
        .load_data_o(load_data_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] eff(input logic [31:0] b, input logic [11:0] o);
        logic [31:0] s = {{20{o[11]}}, o};
        return b + s;
    endfunction

    // Present a request at a falling edge; the next falling edge shows the result.
    task automatic issue(input logic [6:0] opc, input logic [2:0] f3,
                         input logic [31:0] b, input logic [11:0] o, input logic [31:0] sd);
        @(negedge clk);
        req_valid_i = 1'b1; opcode_i = opc; funct3_i = f3;
        base_i = b; offset_i = o; store_data_i = sd;
        @(negedge clk);
        req_valid_i = 1'b0;
    endtask

    // Check the request outputs of an access that was accepted.
    task automatic expect_ok(input string tag, input logic wr, input logic [29:0] a,
                             input logic [3:0] be, input logic [31:0] wd);
        chk({tag, " valid"}, 32'(mem_valid_o), 32'd1);
        chk({tag, " write"}, 32'(mem_write_o), 32'(wr));
        chk({tag, " addr"}, 32'(mem_addr_o), 32'(a));
        chk({tag, " be"}, 32'(mem_be_o), 32'(be));
        if (wr) chk({tag, " wdata"}, mem_wdata_o, wd);
    endtask

    task automatic t_reset();
        chk("R1 valid", 32'(mem_valid_o), 0);
        chk("R1 write", 32'(mem_write_o), 0);
        chk("R1 addr", 32'(mem_addr_o), 0);
        chk("R1 be", 32'(mem_be_o), 0);
        chk("R1 wdata", mem_wdata_o, 0);
        chk("R1 flags", {30'd0, misaligned_o, illegal_o}, 0);
        chk("R1 load", {31'd0, load_valid_o} | load_data_o, 0);
    endtask

    task automatic t_store_bytes();
        for (int k = 0; k < 4; k++) begin
            logic [31:0] ea = eff(32'h0000_1000, 12'(k));
            issue(7'h23, 3'h0, 32'h0000_1000, 12'(k), 32'hDEAD_BEA5);
            expect_ok("R3 sb", 1'b1, ea[31:2], 4'b0001 << k, 32'hA5A5_A5A5);
        end
    endtask

    task automatic t_store_half_word();
        logic [31:0] ea;
        ea = eff(32'h0000_2000, 12'h002);
        issue(7'h23, 3'h1, 32'h0000_2000, 12'h002, 32'h1234_5678);
        expect_ok("R4 sh hi", 1'b1, ea[31:2], 4'b1100, 32'h5678_5678);
        ea = eff(32'h0000_2000, 12'h000);
        issue(7'h23, 3'h1, 32'h0000_2000, 12'h000, 32'h1234_9ABC);
        expect_ok("R4 sh lo", 1'b1, ea[31:2], 4'b0011, 32'h9ABC_9ABC);
        ea = eff(32'h0000_3010, 12'hFF8);
        issue(7'h23, 3'h2, 32'h0000_3010, 12'hFF8, 32'hCAFE_F00D);
        expect_ok("R2 R5 sw neg off", 1'b1, ea[31:2], 4'b1111, 32'hCAFE_F00D);
        chk("R2 neg off addr", 32'(mem_addr_o), 32'h0000_3008 >> 2);
    endtask

    task automatic t_misaligned();
        issue(7'h23, 3'h1, 32'h0000_4000, 12'h003, 32'h1);
        chk("R6 sh odd flag", {misaligned_o, mem_valid_o, mem_be_o}, 6'b100000);
        issue(7'h03, 3'h2, 32'h0000_4000, 12'h002, 32'h0);
        chk("R6 lw flag", {misaligned_o, mem_valid_o, mem_be_o}, 6'b100000);
        issue(7'h03, 3'h0, 32'h0000_4000, 12'h003, 32'h0);
        chk("R6 lb any lane ok", {misaligned_o, mem_valid_o, mem_be_o}, 6'b011000);
    endtask

    task automatic t_illegal();
        logic [2:0] lcodes [3] = '{3'h3, 3'h6, 3'h7};
        for (int k = 0; k < 3; k++) begin
            issue(7'h03, lcodes[k], 32'h0000_5001, 12'h0, 32'h0);
            chk("R7 load code", {illegal_o, misaligned_o, mem_valid_o, mem_be_o}, 7'b1000000);
        end
        for (int k = 3; k < 8; k++) begin
            issue(7'h23, 3'(k), 32'h0000_5001, 12'h0, 32'hFF);
            chk("R7 store code", {illegal_o, misaligned_o, mem_valid_o, mem_be_o}, 7'b1000000);
        end
    endtask

    task automatic t_foreign_opcode();
        issue(7'h33, 3'h0, 32'h0000_6004, 12'h001, 32'h1234_5678);
        chk("R8 ignored", {mem_valid_o, mem_write_o, mem_be_o, misaligned_o, illegal_o}, 0);
        chk("R8 addr", 32'(mem_addr_o), 0);
        chk("R8 wdata", mem_wdata_o, 0);
    endtask

    // Issue a load, return a word, and check the extended result.
    task automatic do_load(input string tag, input logic [2:0] f3, input logic [11:0] o,
                           input logic [31:0] word, input logic [31:0] exp);
        issue(7'h03, f3, 32'h0000_7000, o, 32'h0);
        chk({tag, " issued"}, {31'd0, mem_valid_o & ~mem_write_o}, 1);
        mem_rdata_i = word; mem_rvalid_i = 1'b1;
        @(negedge clk);
        mem_rvalid_i = 1'b0; mem_rdata_i = '0;
        chk({tag, " R12 valid"}, 32'(load_valid_o), 1);
        chk(tag, load_data_o, exp);
        @(negedge clk);
        chk({tag, " R12 one shot"}, 32'(load_valid_o), 0);
    endtask

    task automatic t_loads();
        logic [31:0] w = 32'h80F1_7F82;
        do_load("R9 lb lane0", 3'h0, 12'h000, w, 32'hFFFF_FF82);
        do_load("R9 lb lane1", 3'h0, 12'h001, w, 32'h0000_007F);
        do_load("R9 lb lane3", 3'h0, 12'h003, w, 32'hFFFF_FF80);
        do_load("R9 lh hi", 3'h1, 12'h002, w, 32'hFFFF_80F1);
        do_load("R9 lh lo", 3'h1, 12'h000, w, 32'h0000_7F82);
        do_load("R10 lbu lane2", 3'h4, 12'h002, w, 32'h0000_00F1);
        do_load("R10 lhu hi", 3'h5, 12'h002, w, 32'h0000_80F1);
        do_load("R11 lw", 3'h2, 12'h000, w, w);
    endtask

    // A later rejected load must not change the recorded lane.
    task automatic t_pending_kept();
        issue(7'h03, 3'h4, 32'h0000_7000, 12'h003, 32'h0);
        issue(7'h03, 3'h2, 32'h0000_7000, 12'h001, 32'h0);
        chk("R12 reject seen", 32'(misaligned_o), 1);
        mem_rdata_i = 32'hAB00_0000; mem_rvalid_i = 1'b1;
        @(negedge clk);
        mem_rvalid_i = 1'b0;
        chk("R12 lane kept", load_data_o, 32'h0000_00AB);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_store_bytes();
        t_store_half_word();
        t_misaligned();
        t_illegal();
        t_foreign_opcode();
        t_loads();
        t_pending_kept();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                failures++;
                checks++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule